// File: doc/BRIEF.md
# I2C Bus Condition Controller

This block produces the start, repeated-start and stop conditions that an I2C master places on the two bus wires. It also watches the wires to report whether the bus is in use. Software asks for a condition by writing two control bits in the same write:

- a requested bus-busy value;
- a prohibit bit that acts as a write strobe. When it is 1, the write is thrown away.

The block drives SCL and SDA through active-low pull enables meant for open-drain pads. Each condition is a timed sequence measured in clock cycles.

A bus monitor samples both wires through a two-flop synchronizer. It sets a readable busy flag when SDA falls while SCL is high, and clears it when SDA rises while SCL is high. It does this whether this controller or another device made the edge.

A small acknowledge stage decides how a NACK from the byte engine is treated. It either ignores the NACK, or latches it and tells the byte engine to stop continuous transfer.

Top module: `i2c_cond_ctrl`

## Requirements
- R1: A write with busy=1 and prohibit=0, while master=1, transmit=1 and the bus is not owned, starts a start sequence. On the clock edge that takes the write, `sda_pull_n` goes to 0 and `scl_pull_n` stays 1. Exactly HOLD_CYCLES edges later, `scl_pull_n` goes to 0, `seq_active` returns to 0 and the bus is owned.
- R2: The same write while the bus is owned runs a repeated start, with HOLD_CYCLES edges between each step:
  - SDA is released while SCL is held low;
  - SCL is released;
  - SDA is pulled low;
  - SCL is pulled low.
- R3: A write with busy=0 and prohibit=0, while master=1 and the bus is owned, runs a stop. On the edge that takes the write, SCL is released while SDA stays low. HOLD_CYCLES edges later SDA is released and ownership ends. The same write while the bus is not owned does nothing.
- R4: A write with prohibit=1 changes neither pull output and starts no sequence. `rd_prohibit` always reads 1.
- R5: While master=0 (slave mode), no write starts or ends a condition.
- R6: A start request with transmit=0 is dropped.
- R7: `bus_busy` behaves as follows, whoever drives the wires:
  - it becomes 1 within three clock edges after SDA falls while SCL is high;
  - it becomes 0 within three clock edges after SDA rises while SCL is high;
  - SDA changes while SCL is low leave it unchanged.
- R8: While `ack_check_en`=0, `ack_status` and `halt_xfer` read 0 whatever ack bits arrive.
- R9: While `ack_check_en`=1, a strobe on `ack_valid` with `ack_bit`=1 sets `ack_status` and `halt_xfer` on the next edge. A strobe with `ack_bit`=0 clears both.
- R10: Condition writes that arrive while `seq_active`=1 are ignored, and the running sequence keeps its timing.
- R11: After reset both pull enables read 1 (wires released), and `bus_busy`, `seq_active`, `ack_status` and `halt_xfer` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Strobe for a write of the condition control bits |
| wr_busy | input | 1 | Requested bus-busy value: 1 requests a start, 0 requests a stop |
| wr_prohibit | input | 1 | Prohibit bit; a write with 1 is ignored |
| master_mode | input | 1 | 1 = master, 0 = slave |
| transmit_mode | input | 1 | 1 = transmit direction |
| ack_check_en | input | 1 | 1 = a received NACK halts continuous transfer |
| ack_valid | input | 1 | Strobe from the byte engine: a received ack bit is valid |
| ack_bit | input | 1 | Received ack bit (1 = NACK) |
| scl_in | input | 1 | SCL pad level |
| sda_in | input | 1 | SDA pad level |
| scl_pull_n | output | 1 | Active-low pull enable for the SCL pad |
| sda_pull_n | output | 1 | Active-low pull enable for the SDA pad |
| bus_busy | output | 1 | Bus busy flag from the monitor |
| rd_prohibit | output | 1 | Read value of the prohibit bit (always 1) |
| seq_active | output | 1 | A condition sequence is running |
| ack_status | output | 1 | Latched NACK status |
| halt_xfer | output | 1 | Tells the byte engine to stop continuous transfer |

## Verification
The assertions assume a few things about the inputs:
- nothing else holds SCL low while a sequence runs, because clock stretching is not part of this block;
- the pad inputs stay steady over a clock edge except where the synchronizer absorbs them.

The bench models each pad as the wired AND of the controller's pull enable and an external driver. It moves the external drivers only while the controller is idle, and then only one wire per step. Writes, mode bits and ack strobes are changed on the falling clock edge, so every request is seen whole on exactly one rising edge.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

  // Phases of a condition sequence
  typedef enum logic [2:0] {
    SEQ_IDLE   = 3'd0,
    SEQ_RS_SDA = 3'd1,  // repeated start: SDA released, SCL still low
    SEQ_RS_SCL = 3'd2,  // repeated start: both wires released
    SEQ_START  = 3'd3,  // SDA low with SCL high
    SEQ_STOP   = 3'd4   // SCL released with SDA low
  } seq_state_t;

endpackage

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic bus_busy
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] scl_chain;
  logic [SYNC_STAGES-1:0] sda_chain;
  logic sda_prev;
  logic scl_s, sda_s;
  logic sda_fall, sda_rise;

  // Synchronizer chain, one stage per generate step; an idle bus is high
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_chain[0] <= 1'b1;
          sda_chain[0] <= 1'b1;
        end else begin
          scl_chain[0] <= scl_in;
          sda_chain[0] <= sda_in;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_chain[g] <= 1'b1;
          sda_chain[g] <= 1'b1;
        end else begin
          scl_chain[g] <= scl_chain[g-1];
          sda_chain[g] <= sda_chain[g-1];
        end
      end
    end
  end

  assign scl_s    = scl_chain[LAST];
  assign sda_s    = sda_chain[LAST];
  assign sda_fall = sda_prev & ~sda_s & scl_s;
  assign sda_rise = ~sda_prev & sda_s & scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sda_prev <= 1'b1;
      bus_busy <= 1'b0;
    end else begin
      sda_prev <= sda_s;
      if (sda_fall)      bus_busy <= 1'b1;
      else if (sda_rise) bus_busy <= 1'b0;
    end
  end

  // R7
  busy_set_scl_high_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_busy) |-> $past(scl_s));

  // R7
  busy_clr_sda_high_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_busy) |-> $past(scl_s && sda_s));

endmodule

// File: rtl/i2c_ack_decide.sv
module i2c_ack_decide (
  input  logic clk,
  input  logic rst,
  input  logic ack_check_en,
  input  logic ack_valid,
  input  logic ack_bit,
  output logic ack_status,
  output logic halt_xfer
);

  logic nack_q;

  always_ff @(posedge clk) begin
    if (rst)                nack_q <= 1'b0;
    else if (!ack_check_en) nack_q <= 1'b0;
    else if (ack_valid)     nack_q <= ack_bit;
  end

  assign ack_status = nack_q & ack_check_en;
  assign halt_xfer  = ack_status;

  // R9
  nack_from_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(nack_q) |-> $past(ack_valid && ack_bit && ack_check_en));

  // R8
  ack_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!ack_check_en && !$past(ack_check_en)) |-> !nack_q);

endmodule

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq
  import i2c_cond_pkg::*;
#(
  parameter int HOLD_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  input  logic stop_req,
  output logic active,
  output logic owned,
  output logic scl_low,
  output logic sda_low
);

  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(HOLD_CYCLES - 1);

  seq_state_t    st;
  logic [CW-1:0] cnt;
  logic          cnt_done;

  assign cnt_done = (cnt == '0);
  assign active   = (st != SEQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SEQ_IDLE;
      cnt     <= '0;
      owned   <= 1'b0;
      scl_low <= 1'b0;
      sda_low <= 1'b0;
    end else begin
      unique case (st)
        SEQ_IDLE: begin
          if (start_req) begin
            cnt <= LOAD;
            if (owned) begin
              sda_low <= 1'b0;
              st      <= SEQ_RS_SDA;
            end else begin
              sda_low <= 1'b1;
              st      <= SEQ_START;
            end
          end else if (stop_req && owned) begin
            cnt     <= LOAD;
            scl_low <= 1'b0;
            st      <= SEQ_STOP;
          end
        end
        SEQ_RS_SDA: begin
          if (cnt_done) begin
            scl_low <= 1'b0;
            cnt     <= LOAD;
            st      <= SEQ_RS_SCL;
          end else cnt <= cnt - 1'b1;
        end
        SEQ_RS_SCL: begin
          if (cnt_done) begin
            sda_low <= 1'b1;
            cnt     <= LOAD;
            st      <= SEQ_START;
          end else cnt <= cnt - 1'b1;
        end
        SEQ_START: begin
          if (cnt_done) begin
            scl_low <= 1'b1;
            owned   <= 1'b1;
            st      <= SEQ_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        SEQ_STOP: begin
          if (cnt_done) begin
            sda_low <= 1'b0;
            owned   <= 1'b0;
            st      <= SEQ_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end

  // R1
  start_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == SEQ_START) |-> (sda_low && !scl_low));

  // R3
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == SEQ_STOP) |-> (sda_low && !scl_low));

  // R2
  rs_sda_first_chk: assert property (@(posedge clk) disable iff (rst)
    (st == SEQ_RS_SDA) |-> (scl_low && !sda_low));

  // R2
  rs_both_free_chk: assert property (@(posedge clk) disable iff (rst)
    (st == SEQ_RS_SCL) |-> (!scl_low && !sda_low));

  // R11
  idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
    (st == SEQ_IDLE) |-> (scl_low == owned && sda_low == owned));

  // R10
  busy_ignores_req_chk: assert property (@(posedge clk) disable iff (rst)
    (active && (st != SEQ_START) && (st != SEQ_STOP)) |=> active);

endmodule

// File: rtl/i2c_cond_ctrl.sv
module i2c_cond_ctrl #(
  parameter int HOLD_CYCLES = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic reg_wr,
  input  logic wr_busy,
  input  logic wr_prohibit,
  input  logic master_mode,
  input  logic transmit_mode,
  input  logic ack_check_en,
  input  logic ack_valid,
  input  logic ack_bit,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_pull_n,
  output logic sda_pull_n,
  output logic bus_busy,
  output logic rd_prohibit,
  output logic seq_active,
  output logic ack_status,
  output logic halt_xfer
);

  logic wr_take;
  logic start_req, stop_req;
  logic owned, scl_low, sda_low;

  // Prohibit acts as a strobe gate; slave mode and a running sequence block writes
  assign wr_take   = reg_wr && !wr_prohibit && master_mode && !seq_active;
  assign start_req = wr_take && wr_busy && transmit_mode;
  assign stop_req  = wr_take && !wr_busy;

  i2c_cond_seq #(.HOLD_CYCLES(HOLD_CYCLES)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_req (start_req),
    .stop_req  (stop_req),
    .active    (seq_active),
    .owned     (owned),
    .scl_low   (scl_low),
    .sda_low   (sda_low)
  );

  i2c_bus_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk      (clk),
    .rst      (rst),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .bus_busy (bus_busy)
  );

  i2c_ack_decide u_ack (
    .clk          (clk),
    .rst          (rst),
    .ack_check_en (ack_check_en),
    .ack_valid    (ack_valid),
    .ack_bit      (ack_bit),
    .ack_status   (ack_status),
    .halt_xfer    (halt_xfer)
  );

  assign scl_pull_n  = ~scl_low;
  assign sda_pull_n  = ~sda_low;
  assign rd_prohibit = 1'b1;

  // R4
  lines_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!seq_active && !(reg_wr && !wr_prohibit)) |=> $stable({scl_pull_n, sda_pull_n}));

  // R5
  slave_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!seq_active && !master_mode) |=> !seq_active);

endmodule

// File: tb/test_i2c_cond_ctrl.sv
module test_i2c_cond_ctrl;

  localparam int HOLD = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, wr_busy = 1'b0, wr_prohibit = 1'b1;
  logic master_mode = 1'b1, transmit_mode = 1'b1;
  logic ack_check_en = 1'b0, ack_valid = 1'b0, ack_bit = 1'b0;
  logic ext_scl = 1'b1, ext_sda = 1'b1;
  logic scl_in, sda_in;
  logic scl_pull_n, sda_pull_n, bus_busy, rd_prohibit, seq_active, ack_status, halt_xfer;

  int n_chk = 0;
  int n_bad = 0;
  bit reported = 0;

  always #2.5 clk = ~clk;

  assign scl_in = scl_pull_n & ext_scl;
  assign sda_in = sda_pull_n & ext_sda;

  i2c_cond_ctrl #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(2)) i_i2c_cond_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .wr_busy(wr_busy), .wr_prohibit(wr_prohibit),
    .master_mode(master_mode), .transmit_mode(transmit_mode),
    .ack_check_en(ack_check_en), .ack_valid(ack_valid), .ack_bit(ack_bit),
    .scl_in(scl_in), .sda_in(sda_in), .scl_pull_n(scl_pull_n), .sda_pull_n(sda_pull_n),
    .bus_busy(bus_busy), .rd_prohibit(rd_prohibit), .seq_active(seq_active),
    .ack_status(ack_status), .halt_xfer(halt_xfer)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Leaves the caller just after the edge that took the write
  task automatic write_req(input logic b, input logic p);
    reg_wr = 1'b1; wr_busy = b; wr_prohibit = p;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; wr_prohibit = 1'b1;
  endtask

  task automatic t_reset;
    chk("R11 scl released", scl_pull_n, 1'b1);
    chk("R11 sda released", sda_pull_n, 1'b1);
    chk("R11 busy clear", bus_busy, 1'b0);
    chk("R11 seq idle", seq_active, 1'b0);
    chk("R11 ack clear", ack_status, 1'b0);
    chk("R11 halt clear", halt_xfer, 1'b0);
    chk("R4 prohibit reads 1", rd_prohibit, 1'b1);
  endtask

  task automatic t_external_busy;
    ext_sda = 1'b0; wait_cyc(4);
    chk("R7 busy set by other driver", bus_busy, 1'b1);
    ext_scl = 1'b0; wait_cyc(4);
    ext_sda = 1'b1; wait_cyc(4);
    chk("R7 sda rise with scl low ignored", bus_busy, 1'b1);
    ext_sda = 1'b0; wait_cyc(4);
    ext_scl = 1'b1; wait_cyc(4);
    chk("R7 busy kept", bus_busy, 1'b1);
    ext_sda = 1'b1; wait_cyc(4);
    chk("R7 busy cleared by stop edge", bus_busy, 1'b0);
  endtask

  task automatic t_blocked_unowned;
    write_req(1'b1, 1'b1);
    chk("R4 prohibited start: sda", sda_pull_n, 1'b1);
    chk("R4 prohibited start: idle", seq_active, 1'b0);
    master_mode = 1'b0;
    write_req(1'b1, 1'b0);
    chk("R5 slave start ignored", sda_pull_n, 1'b1);
    master_mode = 1'b1; transmit_mode = 1'b0;
    write_req(1'b1, 1'b0);
    chk("R6 start without transmit dropped", sda_pull_n, 1'b1);
    chk("R6 no sequence", seq_active, 1'b0);
    transmit_mode = 1'b1;
    write_req(1'b0, 1'b0);
    chk("R3 stop while unowned ignored", seq_active, 1'b0);
    wait_cyc(4);
    chk("R5 busy still clear", bus_busy, 1'b0);
  endtask

  task automatic t_start;
    write_req(1'b1, 1'b0);
    chk("R1 sda low first", sda_pull_n, 1'b0);
    chk("R1 scl still high", scl_pull_n, 1'b1);
    chk("R1 active", seq_active, 1'b1);
    wait_cyc(HOLD - 1);
    chk("R1 scl held high for hold", scl_pull_n, 1'b1);
    wait_cyc(1);
    chk("R1 scl low after hold", scl_pull_n, 1'b0);
    chk("R1 done", seq_active, 1'b0);
    chk("R7 busy after own start", bus_busy, 1'b1);
  endtask

  task automatic t_blocked_owned;
    write_req(1'b0, 1'b1);
    chk("R4 prohibited stop: sda", sda_pull_n, 1'b0);
    chk("R4 prohibited stop: scl", scl_pull_n, 1'b0);
    master_mode = 1'b0;
    write_req(1'b0, 1'b0);
    chk("R5 slave stop ignored", scl_pull_n, 1'b0);
    master_mode = 1'b1;
  endtask

  task automatic t_rstart;
    write_req(1'b1, 1'b0);
    chk("R2 sda released first", sda_pull_n, 1'b1);
    chk("R2 scl still low", scl_pull_n, 1'b0);
    write_req(1'b0, 1'b0);               // R10: stop while active
    chk("R10 scl unchanged", scl_pull_n, 1'b0);
    wait_cyc(HOLD - 2);
    chk("R2 scl low until hold", scl_pull_n, 1'b0);
    wait_cyc(1);
    chk("R2 scl released", scl_pull_n, 1'b1);
    chk("R2 sda still released", sda_pull_n, 1'b1);
    wait_cyc(HOLD);
    chk("R2 sda low again", sda_pull_n, 1'b0);
    chk("R2 scl high at start", scl_pull_n, 1'b1);
    wait_cyc(HOLD);
    chk("R2 scl low at end", scl_pull_n, 1'b0);
    chk("R10 sequence finished as timed", seq_active, 1'b0);
    chk("R7 busy held over repeated start", bus_busy, 1'b1);
  endtask

  task automatic t_stop;
    write_req(1'b0, 1'b0);
    chk("R3 scl released first", scl_pull_n, 1'b1);
    chk("R3 sda held low", sda_pull_n, 1'b0);
    wait_cyc(HOLD - 1);
    chk("R3 sda low until hold", sda_pull_n, 1'b0);
    wait_cyc(1);
    chk("R3 sda released", sda_pull_n, 1'b1);
    chk("R3 done", seq_active, 1'b0);
    wait_cyc(4);
    chk("R7 busy cleared by own stop", bus_busy, 1'b0);
  endtask

  task automatic t_ack;
    ack_check_en = 1'b0; ack_valid = 1'b1; ack_bit = 1'b1;
    wait_cyc(1); ack_valid = 1'b0;
    chk("R8 status ignored", ack_status, 1'b0);
    chk("R8 no halt", halt_xfer, 1'b0);
    ack_check_en = 1'b1; ack_valid = 1'b1; ack_bit = 1'b1;
    wait_cyc(1); ack_valid = 1'b0;
    chk("R9 nack latched", ack_status, 1'b1);
    chk("R9 halt raised", halt_xfer, 1'b1);
    ack_valid = 1'b1; ack_bit = 1'b0;
    wait_cyc(1); ack_valid = 1'b0;
    chk("R9 ack clears", halt_xfer, 1'b0);
    ack_valid = 1'b1; ack_bit = 1'b1;
    wait_cyc(1); ack_valid = 1'b0;
    ack_check_en = 1'b0; #1;
    chk("R8 disabled reads 0", ack_status, 1'b0);
  endtask

  task automatic finish_run;
    if (!reported) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    wait_cyc(1);
    t_reset;
    t_external_busy;
    t_blocked_unowned;
    t_start;
    t_blocked_owned;
    t_rstart;
    t_stop;
    t_ack;
    wait_cyc(2);
    finish_run;
  end

  initial begin
    #(5 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run;
  end

endmodule